// File: doc/BRIEF.md
# Hierarchical Interrupt and Halt Aggregator

This block sits above four leaf modules (A, B, C, D). Each leaf reports two masked summary bits: one that asks for an interrupt and one that asks for a halt. The block merges these bits in two stages.

At the first stage, two read-only registers show the leaf bits as they arrive. Each has a bank of per-module enables that software can write. At the second stage, a two-bit global status register shows whether any enabled module is requesting, one bit for each path. A two-bit global enable then gates the single interrupt line and the single halt line that leave the block.

None of the status bits latch. Each status bit follows the bits beneath it, so software clears the whole chain only by servicing the leaves. The interrupt path and the halt path run side by side through separate enables and never mix. Software reaches the six registers through a simple write strobe with an address. Read data is combinational from the address.

Top module: `hia_aggregator`

## Requirements
- R1: After reset, the per-module interrupt enables, the per-module halt enables and the global enables all read 0. `irq_o` and `halt_o` are low.
- R2: Address 0x1000 reads the leaf interrupt summaries in bits [3:0], module A at bit 0 up to module D at bit 3. The upper bits read 0. The value follows `leaf_int_i` in the same cycle and does not latch.
- R3: Address 0x1004 reads the leaf halt summaries in bits [3:0], with the same module order. The value follows `leaf_halt_i` in the same cycle and does not latch.
- R4: Address 0x1008 holds the per-module interrupt enables in bits [3:0], where 1 means enabled. A write loads `reg_wdata_i[3:0]` at the clock edge. The upper bits read 0.
- R5: Address 0x100C holds the per-module halt enables in bits [3:0], where 1 means enabled. These bits are written and read the same way as R4.
- R6: Address 0x1010 reads the global status. Bit 0 is the OR of (leaf interrupt AND interrupt enable) over all modules. Bit 1 is the OR of (leaf halt AND halt enable). Both bits are taken before the global enables are applied.
- R7: Address 0x1014 holds the global interrupt enable at bit 0 and the global halt enable at bit 1. A write loads these two bits. The upper bits read 0.
- R8: `irq_o` equals global status bit 0 AND the global interrupt enable. `halt_o` equals global status bit 1 AND the global halt enable. Both respond combinationally to leaf changes, with no register on the path.
- R9: Writes to 0x1000, 0x1004 and 0x1010 are ignored. Every enable register keeps its value, and the status bits still follow the leaves.
- R10: The interrupt path and the halt path are independent. Halt enables and leaf halt bits never affect `irq_o`, and the interrupt-side enables and leaf bits never affect `halt_o`.
- R11: Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| leaf_int_i | input | 4 | Interrupt summary per leaf module (bit 0 = A) |
| leaf_halt_i | input | 4 | Halt summary per leaf module (bit 0 = A) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Global interrupt line |
| halt_o | output | 1 | Global halt line |

## Verification
The hardest case to reach is one where the two paths disagree. For example, a module may have its halt enabled while its interrupt is masked, with both global enables set. A bug that crosses the enable banks then produces a plausible but wrong output. The vector table pairs leaf patterns with enable patterns so that in several rows one path fires and the other stays quiet. Each row also reads the pre-mask global status, so the two stages of masking are checked separately. Directed tests then move leaf bits between clock edges to show that the lines track without latency and fall again once the leaves clear.

// File: rtl/hia_pkg.sv
package hia_pkg;

  // Register byte offsets
  localparam int unsigned HIA_OFS_MINT_STAT  = 32'h1000;
  localparam int unsigned HIA_OFS_MHALT_STAT = 32'h1004;
  localparam int unsigned HIA_OFS_MINT_EN    = 32'h1008;
  localparam int unsigned HIA_OFS_MHALT_EN   = 32'h100C;
  localparam int unsigned HIA_OFS_GLB_STAT   = 32'h1010;
  localparam int unsigned HIA_OFS_GLB_EN     = 32'h1014;

  // Path indices used in the two-lane arrays
  localparam int HIA_PATH_INT  = 0;
  localparam int HIA_PATH_HALT = 1;
  localparam int HIA_NUM_PATHS = 2;

  // True when any source bit is both set and enabled
  function automatic logic hia_any_enabled(input logic [31:0] src,
                                           input logic [31:0] en);
    return |(src & en);
  endfunction

  // A lane summary passes only when its global enable is set
  function automatic logic hia_gate(input logic summary, input logic glb_en);
    return summary & glb_en;
  endfunction

endpackage

// File: rtl/hia_rw_field.sv
module hia_rw_field #(
  parameter int          WIDTH  = 4,
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 32,
  parameter int unsigned OFFSET = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [WIDTH-1:0]  q_o
);

  logic             hit;
  logic [WIDTH-1:0] wr_slice;

  assign hit      = wr_i && (addr_i == ADDR_W'(OFFSET));
  assign wr_slice = wdata_i[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else if (hit) q_o <= wr_slice;
  end

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (q_o == $past(wr_slice))); // R4

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(q_o)); // R11

endmodule

// File: rtl/hia_cfg_regs.sv
module hia_cfg_regs
  import hia_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_MOD-1:0] int_en_o,
  output logic [NUM_MOD-1:0] halt_en_o,
  output logic [1:0]         glb_en_o
);

  // Per-module interrupt enables
  hia_rw_field #(
    .WIDTH (NUM_MOD),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFFSET(HIA_OFS_MINT_EN)
  ) u_int_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .q_o    (int_en_o)
  );

  // Per-module halt enables
  hia_rw_field #(
    .WIDTH (NUM_MOD),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFFSET(HIA_OFS_MHALT_EN)
  ) u_halt_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .q_o    (halt_en_o)
  );

  // Global enables: bit 0 interrupt, bit 1 halt
  hia_rw_field #(
    .WIDTH (HIA_NUM_PATHS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFFSET(HIA_OFS_GLB_EN)
  ) u_glb_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .q_o    (glb_en_o)
  );

endmodule

// File: rtl/hia_reduce.sv
module hia_reduce
  import hia_pkg::*;
#(
  parameter int NUM_MOD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MOD-1:0] stat_i,
  input  logic [NUM_MOD-1:0] en_i,
  input  logic               glb_en_i,
  output logic               any_o,
  output logic               line_o
);

  assign any_o  = hia_any_enabled(32'(stat_i), 32'(en_i));
  assign line_o = hia_gate(any_o, glb_en_i);

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> !line_o); // R8

  AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |-> (!any_o && !line_o)); // R6

endmodule

// File: rtl/hia_aggregator.sv
module hia_aggregator
  import hia_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MOD-1:0] leaf_int_i,
  input  logic [NUM_MOD-1:0] leaf_halt_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               halt_o
);

  logic [NUM_MOD-1:0] int_en;
  logic [NUM_MOD-1:0] halt_en;
  logic [1:0]         glb_en;

  // Per-lane views, indexed by HIA_PATH_INT / HIA_PATH_HALT
  logic [HIA_NUM_PATHS-1:0][NUM_MOD-1:0] lane_stat;
  logic [HIA_NUM_PATHS-1:0][NUM_MOD-1:0] lane_en;
  logic [HIA_NUM_PATHS-1:0]              lane_any;
  logic [HIA_NUM_PATHS-1:0]              lane_line;

  // Named decode events
  logic status_write;

  hia_cfg_regs #(
    .NUM_MOD(NUM_MOD),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .int_en_o (int_en),
    .halt_en_o(halt_en),
    .glb_en_o (glb_en)
  );

  assign lane_stat[HIA_PATH_INT]  = leaf_int_i;
  assign lane_stat[HIA_PATH_HALT] = leaf_halt_i;
  assign lane_en[HIA_PATH_INT]    = int_en;
  assign lane_en[HIA_PATH_HALT]   = halt_en;

  for (genvar p = 0; p < HIA_NUM_PATHS; p++) begin : g_lane
    hia_reduce #(
      .NUM_MOD(NUM_MOD)
    ) u_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_i  (lane_stat[p]),
      .en_i    (lane_en[p]),
      .glb_en_i(glb_en[p]),
      .any_o   (lane_any[p]),
      .line_o  (lane_line[p])
    );
  end

  assign irq_o  = lane_line[HIA_PATH_INT];
  assign halt_o = lane_line[HIA_PATH_HALT];

  // Combinational read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(HIA_OFS_MINT_STAT))
      reg_rdata_o[NUM_MOD-1:0] = leaf_int_i;
    else if (reg_addr_i == ADDR_W'(HIA_OFS_MHALT_STAT))
      reg_rdata_o[NUM_MOD-1:0] = leaf_halt_i;
    else if (reg_addr_i == ADDR_W'(HIA_OFS_MINT_EN))
      reg_rdata_o[NUM_MOD-1:0] = int_en;
    else if (reg_addr_i == ADDR_W'(HIA_OFS_MHALT_EN))
      reg_rdata_o[NUM_MOD-1:0] = halt_en;
    else if (reg_addr_i == ADDR_W'(HIA_OFS_GLB_STAT))
      reg_rdata_o[HIA_NUM_PATHS-1:0] = lane_any;
    else if (reg_addr_i == ADDR_W'(HIA_OFS_GLB_EN))
      reg_rdata_o[HIA_NUM_PATHS-1:0] = glb_en;
  end

  assign status_write = reg_wr_i &&
                        ((reg_addr_i == ADDR_W'(HIA_OFS_MINT_STAT))  ||
                         (reg_addr_i == ADDR_W'(HIA_OFS_MHALT_STAT)) ||
                         (reg_addr_i == ADDR_W'(HIA_OFS_GLB_STAT)));

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    status_write |=> ($stable(int_en) && $stable(halt_en) && $stable(glb_en))); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((leaf_int_i & int_en) != '0)); // R10

  AST_HALT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> ((leaf_halt_i & halt_en) != '0)); // R10

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !halt_o)); // R1

endmodule

// File: tb/hia_aggregator_tb.sv
`timescale 1ns/1ps
module hia_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  leaf_int = '0;
  logic [3:0]  leaf_halt = '0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        halt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  hia_aggregator u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .leaf_int_i (leaf_int),
    .leaf_halt_i(leaf_halt),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq),
    .halt_o     (halt)
  );

  localparam logic [15:0] A_MINT = 16'h1000;
  localparam logic [15:0] A_MHLT = 16'h1004;
  localparam logic [15:0] A_IEN  = 16'h1008;
  localparam logic [15:0] A_HEN  = 16'h100C;
  localparam logic [15:0] A_GST  = 16'h1010;
  localparam logic [15:0] A_GEN  = 16'h1014;

  // {leaf_int, leaf_halt, int_en, halt_en, glb_en, exp_gstat, exp_irq, exp_halt}
  localparam int NVEC = 6;
  localparam logic [21:0] VEC [NVEC] = '{
    {4'b0001, 4'b0000, 4'b0001, 4'b0000, 2'b01, 2'b01, 1'b1, 1'b0},
    {4'b0100, 4'b1000, 4'b0011, 4'b1000, 2'b11, 2'b10, 1'b0, 1'b1},
    {4'b1111, 4'b1111, 4'b1111, 4'b1111, 2'b00, 2'b11, 1'b0, 1'b0},
    {4'b1010, 4'b0101, 4'b1000, 4'b0001, 2'b11, 2'b11, 1'b1, 1'b1},
    {4'b0010, 4'b0010, 4'b0010, 4'b0000, 2'b10, 2'b01, 1'b0, 1'b0},
    {4'b1000, 4'b0100, 4'b0111, 4'b1011, 2'b11, 2'b00, 1'b0, 1'b0}
  };

  function automatic void check(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endfunction

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check(irq == 1'b0 && halt == 1'b0, "R1 lines low", {30'b0, irq, halt}, 0);
    reg_read(A_IEN, d); check(d == 0, "R1 int enables", d, 0);
    reg_read(A_HEN, d); check(d == 0, "R1 halt enables", d, 0);
    reg_read(A_GEN, d); check(d == 0, "R1 global enables", d, 0);

    // R4 R5 R7: enable write and readback, upper bits read 0
    reg_write(A_IEN, 32'hFFFF_FFF5);
    reg_read(A_IEN, d); check(d == 32'h5, "R4 int enable readback", d, 32'h5);
    reg_write(A_HEN, 32'hFFFF_FFFA);
    reg_read(A_HEN, d); check(d == 32'hA, "R5 halt enable readback", d, 32'hA);
    reg_write(A_GEN, 32'hFFFF_FFFE);
    reg_read(A_GEN, d); check(d == 32'h2, "R7 global enable readback", d, 32'h2);

    // R2 R3: status mirrors, non-sticky
    @(negedge clk); leaf_int = 4'b1001; leaf_halt = 4'b0110;
    reg_read(A_MINT, d); check(d == 32'h9, "R2 master int status", d, 32'h9);
    reg_read(A_MHLT, d); check(d == 32'h6, "R3 master halt status", d, 32'h6);
    @(negedge clk); leaf_int = 4'b0000; leaf_halt = 4'b0000;
    reg_read(A_MINT, d); check(d == 0, "R2 status clears with leaves", d, 0);
    reg_read(A_MHLT, d); check(d == 0, "R3 status clears with leaves", d, 0);

    // R6 R8 R10: vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      v = VEC[i];
      reg_write(A_IEN, {28'b0, v[13:10]});
      reg_write(A_HEN, {28'b0, v[9:6]});
      reg_write(A_GEN, {30'b0, v[5:4]});
      @(negedge clk);
      leaf_int = v[21:18]; leaf_halt = v[17:14];
      reg_read(A_GST, d);
      check(d == {30'b0, v[3:2]}, "R6 global status", d, {30'b0, v[3:2]});
      check(irq == v[1], "R8 irq line", {31'b0, irq}, {31'b0, v[1]});
      check(halt == v[0], "R10 halt line", {31'b0, halt}, {31'b0, v[0]});
    end

    // R8: combinational response between clock edges
    reg_write(A_IEN, 32'hF);
    reg_write(A_HEN, 32'hF);
    reg_write(A_GEN, 32'h3);
    @(posedge clk); #1;
    leaf_int = 4'b0100; leaf_halt = 4'b0000;
    #0.5;
    check(irq == 1'b1 && halt == 1'b0, "R8 irq rises without clock", {30'b0, irq, halt}, 32'h2);
    leaf_int = 4'b0000; leaf_halt = 4'b0001;
    #0.5;
    check(irq == 1'b0 && halt == 1'b1, "R8 lines track leaves", {30'b0, irq, halt}, 32'h1);

    // R10: halt enable does not open interrupt path and vice versa
    reg_write(A_IEN, 32'h0);
    reg_write(A_HEN, 32'hF);
    @(negedge clk); leaf_int = 4'b1111; leaf_halt = 4'b0000; #1;
    check(irq == 1'b0 && halt == 1'b0, "R10 int masked with halt en set", {30'b0, irq, halt}, 0);
    reg_write(A_IEN, 32'hF);
    reg_write(A_HEN, 32'h0);
    @(negedge clk); leaf_int = 4'b0000; leaf_halt = 4'b1111; #1;
    check(irq == 1'b0 && halt == 1'b0, "R10 halt masked with int en set", {30'b0, irq, halt}, 0);

    // R9: writes to status registers ignored
    reg_write(A_HEN, 32'h3);
    reg_write(A_GEN, 32'h1);
    @(negedge clk); leaf_int = 4'b0010; leaf_halt = 4'b0001;
    reg_write(A_MINT, 32'h0);
    reg_write(A_MHLT, 32'hF);
    reg_write(A_GST, 32'h0);
    reg_read(A_IEN, d); check(d == 32'hF, "R9 int enables kept", d, 32'hF);
    reg_read(A_HEN, d); check(d == 32'h3, "R9 halt enables kept", d, 32'h3);
    reg_read(A_GEN, d); check(d == 32'h1, "R9 global enables kept", d, 32'h1);
    reg_read(A_MINT, d); check(d == 32'h2, "R9 int status still mirrors", d, 32'h2);
    reg_read(A_GST, d); check(d == 32'h3, "R9 global status still live", d, 32'h3);

    // R11: unmapped address
    reg_write(16'h1018, 32'hFFFF_FFFF);
    reg_write(16'h0008, 32'h0);
    reg_read(16'h1018, d); check(d == 0, "R11 unmapped reads zero", d, 0);
    reg_read(A_IEN, d); check(d == 32'hF, "R11 unmapped write no effect", d, 32'hF);
    reg_read(A_GEN, d); check(d == 32'h1, "R11 global enable unchanged", d, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule